// File: doc/BRIEF.md
# Carry-Skip Block Adder

This block adds two unsigned operands and a carry-in with no clock. The operand width is split into equal slices. Each slice ripples a carry through a chain of full-adder cells. Every bit also produces a propagate term, the XOR of its two operand bits, and a generate term, their AND. The AND of all propagate terms in a slice drives a bypass multiplexer. When every bit of the slice propagates, the multiplexer hands the slice's incoming carry straight to the next slice. In all other cases it forwards the carry that the local chain produced.

The sum bits of a slice always come from its local chain. That chain is fed by the carry that actually enters the slice. The carry-out of the whole block is the bypass output of the most significant slice. The block is meant as a drop-in datapath adder. Its worst path is setup, then the larger of the select delay and one slice of ripple, then one bypass per middle slice, then the final slice's ripple to its sum bits. The total width and the slice width are parameters, and the slice width must divide the total width.

Top module: `skip_block_adder`

## Requirements
- R1: For every input, {cout, sum} equals op_a + op_b + cin, computed as an unsigned value WIDTH+1 bits wide, with cout as bit WIDTH.
- R2: When op_b is the bitwise inverse of op_a, every slice propagates. With cin = 0 the sum is all ones and cout is 0. With cin = 1 the sum is all zeros and cout is 1.
- R3: The carry leaving slice k equals bit (k+1)*SLICE of the arithmetic sum of the operand bits below that position plus cin. A run of generating slices therefore carries all the way to cout.
- R4: A carry that bypasses fully propagating slices reaches the sum bits of the first slice that does not propagate. Example: 0x0FFF + 0x0000 + 1 gives 0x1000.
- R5: Inside a slice whose propagate terms are all 1, the local ripple carry-out equals the slice carry-in. The bypass and the chain therefore never disagree.
- R6: A slice that has a generating bit at its top position sends a carry of 1 onward whatever its carry-in. A slice whose top bit has both operand bits 0 sends a carry of 0 onward even when its carry-in is 1.
- R7: With WIDTH = 8 and SLICE = 2, the block meets R1 and R2 on 8-bit operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into the least significant slice |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the most significant slice's bypass multiplexer |

## Verification
The bench builds two copies of the block. The first uses the default 16-bit width with 4-bit slices, which gives four slices and three inner bypass hops. The second uses an 8-bit width with 2-bit slices, so a different slice count and slice length are exercised by the same generate structure. Both copies receive directed patterns for full propagation, bypass into a later slice, generation and kill at slice tops, and the all-ones overflow case. Both then receive ten thousand random operand and carry-in vectors, each scored against a plain integer sum that includes the carry-out.

// File: rtl/sba_pkg.sv
package sba_pkg;

  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  function automatic logic fa_carry(input logic gen, input logic x, input logic y,
                                    input logic ci);
    return gen | (ci & (x | y));
  endfunction

endpackage

// File: rtl/sba_bit_cell.sv
module sba_bit_cell
  import sba_pkg::*;
(
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co,
  output logic prop
);

  logic gen;

  always_comb begin
    gen  = x & y;
    prop = x ^ y;
    s    = fa_sum(x, y, ci);
    co   = fa_carry(gen, x, y, ci);
  end

endmodule

// File: rtl/sba_bypass_mux.sv
module sba_bypass_mux (
  input  logic sel,
  input  logic c_in,
  input  logic c_local,
  output logic c_out
);

  always_comb begin
    if (sel) c_out = c_in;
    else     c_out = c_local;
  end

endmodule

// File: rtl/sba_ripple_slice.sv
module sba_ripple_slice #(
  parameter int SW = 4
) (
  input  logic [SW-1:0] a,
  input  logic [SW-1:0] b,
  input  logic          cin,
  output logic [SW-1:0] s,
  output logic          c_local,
  output logic          all_prop
);

  logic [SW:0]   chain;
  logic [SW-1:0] pvec;

  assign chain[0] = cin;

  for (genvar i = 0; i < SW; i++) begin : g_bit
    sba_bit_cell u_cell (
      .x    (a[i]),
      .y    (b[i]),
      .ci   (chain[i]),
      .s    (s[i]),
      .co   (chain[i+1]),
      .prop (pvec[i])
    );
  end

  assign c_local  = chain[SW];
  assign all_prop = &pvec;

  logic [SW:0] ref_val;

  always_comb begin
    ref_val = {1'b0, a} + {1'b0, b} + {{SW{1'b0}}, cin};
    // R4: slice sum bits follow the actual carry-in
    a_r4_slice_arith: assert ({c_local, s} == ref_val)
      else $error("slice arithmetic mismatch");
    // R5: chain agrees with bypass when fully propagating
    if (all_prop) begin
      a_r5_chain_agrees: assert (c_local == cin)
        else $error("ripple carry disagrees with bypass");
    end
  end

endmodule

// File: rtl/skip_block_adder.sv
module skip_block_adder #(
  parameter int WIDTH = 16,
  parameter int SLICE = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NSLICE = WIDTH / SLICE;

  logic [NSLICE:0]   cc;
  logic [NSLICE-1:0] c_loc;
  logic [NSLICE-1:0] skip;

  assign cc[0] = cin;

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    localparam int LO = k * SLICE;
    localparam int HI = LO + SLICE - 1;

    sba_ripple_slice #(.SW(SLICE)) u_slice (
      .a        (op_a[HI:LO]),
      .b        (op_b[HI:LO]),
      .cin      (cc[k]),
      .s        (sum[HI:LO]),
      .c_local  (c_loc[k]),
      .all_prop (skip[k])
    );

    sba_bypass_mux u_mux (
      .sel     (skip[k]),
      .c_in    (cc[k]),
      .c_local (c_loc[k]),
      .c_out   (cc[k+1])
    );

    logic [HI+1:0] prefix;

    always_comb begin
      prefix = {1'b0, op_a[HI:0]} + {1'b0, op_b[HI:0]} + {{(HI+1){1'b0}}, cin};
      // R3: slice carry matches the arithmetic prefix carry
      a_r3_slice_carry: assert (cc[k+1] == prefix[HI+1])
        else $error("slice carry mismatch");
      // R2: a fully propagating slice passes its carry-in unchanged
      if (skip[k]) begin
        a_r2_bypass_pass: assert (cc[k+1] == cc[k])
          else $error("bypass did not pass carry");
      end
    end
  end

  assign cout = cc[NSLICE];

  logic [WIDTH:0] total;

  always_comb begin
    total = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, cin};
    a_r1_total: assert ({cout, sum} == total)
      else $error("total sum mismatch");
  end

endmodule

// File: tb/sim_skip_block_adder.sv
`timescale 1ns/1ps
module sim_skip_block_adder;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [15:0] a16, b16, s16;
  logic [7:0]  a8, b8, s8;
  logic        ci, co16, co8;

  skip_block_adder #(.WIDTH(16), .SLICE(4)) u0 (
    .op_a(a16), .op_b(b16), .cin(ci), .sum(s16), .cout(co16));

  skip_block_adder #(.WIDTH(8), .SLICE(2)) u1 (
    .op_a(a8), .op_b(b8), .cin(ci), .sum(s8), .cout(co8));

  string       q_tag[$];
  logic [16:0] q_e16[$];
  logic [8:0]  q_e8[$];

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  task automatic drive(input logic [15:0] a, input logic [15:0] b,
                       input logic c, input string tag);
    @(negedge clk);
    a16 = a; b16 = b; a8 = a[7:0]; b8 = b[7:0]; ci = c;
    q_tag.push_back(tag);
    q_e16.push_back({1'b0, a} + {1'b0, b} + {16'd0, c});
    q_e8.push_back({1'b0, a[7:0]} + {1'b0, b[7:0]} + {8'd0, c});
  endtask

  always @(posedge clk) begin
    if (!rst && q_tag.size() > 0) begin
      string       t;
      logic [16:0] e16;
      logic [8:0]  e8;
      t   = q_tag.pop_front();
      e16 = q_e16.pop_front();
      e8  = q_e8.pop_front();
      total++;
      if ({co16, s16} !== e16) begin
        bad++;
        $display("FAIL %s width16 actual=%h expected=%h", t, {co16, s16}, e16);
      end
      total++;
      if ({co8, s8} !== e8) begin
        bad++;
        $display("FAIL %s R7 width8 actual=%h expected=%h", t, {co8, s8}, e8);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 60000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 60000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    a16 = '0; b16 = '0; a8 = '0; b8 = '0; ci = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    drive(16'h0000, 16'h0000, 1'b0, "R1 zero");
    drive(16'h1234, ~16'h1234, 1'b0, "R2 all propagate cin0");
    drive(16'h1234, ~16'h1234, 1'b1, "R2 all propagate cin1");
    drive(16'hA5C3, ~16'hA5C3, 1'b1, "R2 all propagate cin1 b");
    drive(16'hFFFF, 16'hFFFF, 1'b1, "R3 all generate");
    drive(16'h8000, 16'h8000, 1'b0, "R3 top generate");
    drive(16'h0888, 16'h0888, 1'b0, "R3 slice tops generate");
    drive(16'h0FFF, 16'h0000, 1'b1, "R4 bypass into slice 3");
    drive(16'h00FF, 16'h0000, 1'b1, "R4 bypass into slice 2");
    drive(16'h0008, 16'h0008, 1'b0, "R6 generate at slice top");
    drive(16'h007F, 16'h0000, 1'b1, "R6 kill at slice top");
    drive(16'h0077, 16'h0008, 1'b1, "R6 mixed generate kill");
    for (int i = 0; i < 10000; i++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      drive(ra, rb, 1'($urandom), "R1 random");
    end
    while (q_tag.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule